// File: doc/BRIEF.md
# Two-Level Response Folding Signature Compactor

This block reduces the captured response of a clustered, randomly addressed scan array to a short signature. The scan cells are arranged as rows of clusters, and each cluster holds a fixed number of cells. The response bits of the cells inside one cluster are combined by exclusive-OR into one cluster bit. The cluster bits along one row are then combined into one row bit. Each row bit feeds one stage of a multiple-input signature register (MISR), so the register has exactly as many stages as the array has rows.

The tester raises the compaction enable once for each captured response, and the MISR folds the row bits into its state. When the test ends, the tester raises the unload enable. The register then acts as a plain right shift register, so the signature leaves on one serial pin with the lowest stage first.

Top module: `resp_compactor`

## Requirements
- R1: Response bit index `(r*NCLUS + c)*NCELL + k` belongs to cell k of cluster c in row r. The cluster bit of cluster c in row r is the XOR of its NCELL cell bits, so two set cells in one cluster cancel.
- R2: The row bit of row r is the XOR of the NCLUS cluster bits of that row, so set bits in two different clusters of one row cancel.
- R3: The MISR has NROWS stages. When `compact_en` is 1 and `unload_en` is 0, the next state is `(S >> 1) ^ (S[0] ? TAPS : 0) ^ row_bits`, where bit r of `row_bits` is the row bit of row r. The default TAPS is 4'hC, which gives a primitive degree-4 feedback.
- R4: A synchronous active-high `rst` clears every MISR stage to 0, so `sig_o` is 0 after reset.
- R5: When both enables are 0, the MISR state does not change.
- R6: When `unload_en` is 1, the next state is `S >> 1` with a 0 entering the top stage. `sig_o` always shows stage 0, so the signature leaves least significant stage first, followed by zeros.
- R7: When both enables are 1, the unload takes priority and the response is not folded in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| resp_i | input | NROWS*NCLUS*NCELL | Captured response bits, indexed as in R1 |
| compact_en | input | 1 | Fold the current response into the MISR |
| unload_en | input | 1 | Shift the signature out by one stage |
| sig_o | output | 1 | Serial signature output, equal to MISR stage 0 |

## Verification
The bench uses the default parameters: 4 rows, 4 clusters per row, 2 cells per cluster, and taps 4'hC. This gives a 32-bit response. A single set cell at any of the 32 positions lands on a known row bit, and both cancellation patterns fit in one stimulus. A 4-stage signature unloads in four cycles, so the zero fill after it can be observed right away, and random runs cycle the feedback through its full period many times.

// File: rtl/rcmp_pkg.sv
package rcmp_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD    = 2'd0,
        MODE_FOLD    = 2'd1,
        MODE_UNLOAD  = 2'd2
    } misr_mode_e;

    // Unload wins over compaction when both are requested.
    function automatic misr_mode_e pick_mode(input logic fold, input logic unload);
        if (unload)
            return MODE_UNLOAD;
        else if (fold)
            return MODE_FOLD;
        else
            return MODE_HOLD;
    endfunction
endpackage

// File: rtl/cluster_fold.sv
module cluster_fold #(
    parameter int NROWS = 4,
    parameter int NCLUS = 4,
    parameter int NCELL = 2,
    localparam int NGRP = NROWS * NCLUS,
    localparam int W    = NGRP * NCELL
) (
    input  logic [W-1:0]    resp_i,
    output logic [NGRP-1:0] clus_o
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign clus_o[g] = ^resp_i[g*NCELL +: NCELL];
    end
endmodule

// File: rtl/row_fold.sv
module row_fold #(
    parameter int NROWS = 4,
    parameter int NCLUS = 4,
    localparam int NGRP = NROWS * NCLUS
) (
    input  logic [NGRP-1:0]  clus_i,
    output logic [NROWS-1:0] row_o
);
    for (genvar r = 0; r < NROWS; r++) begin : g_row
        assign row_o[r] = ^clus_i[r*NCLUS +: NCLUS];
    end
endmodule

// File: rtl/misr_core.sv
module misr_core
    import rcmp_pkg::*;
#(
    parameter int NROWS = 4,
    parameter logic [NROWS-1:0] TAPS = 4'hC
) (
    input  logic             clk,
    input  logic             rst,
    input  misr_mode_e       mode,
    input  logic [NROWS-1:0] row_i,
    output logic [NROWS-1:0] state_q
);
    logic [NROWS-1:0] shifted;
    logic [NROWS-1:0] state_d;

    assign shifted = state_q >> 1;

    always_comb begin
        unique case (mode)
            MODE_FOLD:   state_d = shifted ^ (state_q[0] ? TAPS : '0) ^ row_i;
            MODE_UNLOAD: state_d = shifted;
            default:     state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else
            state_q <= state_d;
    end
endmodule

// File: rtl/resp_compactor.sv
module resp_compactor
    import rcmp_pkg::*;
#(
    parameter int NROWS = 4,
    parameter int NCLUS = 4,
    parameter int NCELL = 2,
    parameter logic [NROWS-1:0] TAPS = 4'hC,
    localparam int NGRP = NROWS * NCLUS,
    localparam int W    = NGRP * NCELL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] resp_i,
    input  logic         compact_en,
    input  logic         unload_en,
    output logic         sig_o
);
    logic [NGRP-1:0]  clus_bits;
    logic [NROWS-1:0] row_bits;
    logic [NROWS-1:0] sig_state;
    misr_mode_e       mode;

    assign mode = pick_mode(compact_en, unload_en);

    cluster_fold #(.NROWS(NROWS), .NCLUS(NCLUS), .NCELL(NCELL)) u_cfold (
        .resp_i (resp_i),
        .clus_o (clus_bits)
    );

    row_fold #(.NROWS(NROWS), .NCLUS(NCLUS)) u_rfold (
        .clus_i (clus_bits),
        .row_o  (row_bits)
    );

    misr_core #(.NROWS(NROWS), .TAPS(TAPS)) u_misr (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .row_i   (row_bits),
        .state_q (sig_state)
    );

    assign sig_o = sig_state[0];
endmodule

// File: rtl/resp_compactor_chk.sv
module resp_compactor_chk #(
    parameter int NROWS = 4,
    parameter int W     = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [W-1:0]     resp_i,
    input logic             compact_en,
    input logic             unload_en,
    input logic [NROWS-1:0] sig_state
);
    // R4
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (sig_state == '0));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!compact_en && !unload_en) |=> $stable(sig_state));

    // R6
    unload_fill_chk: assert property (@(posedge clk) disable iff (rst)
        unload_en |=> (sig_state[NROWS-1] == 1'b0));

    // R6
    unload_move_chk: assert property (@(posedge clk) disable iff (rst)
        unload_en |=> (sig_state[NROWS-2:0] == $past(sig_state[NROWS-1:1])));

    // R3
    quiet_fold_chk: assert property (@(posedge clk) disable iff (rst)
        (compact_en && !unload_en && sig_state == '0 && resp_i == '0) |=> (sig_state == '0));
endmodule

bind resp_compactor resp_compactor_chk #(.NROWS(NROWS), .W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .resp_i     (resp_i),
    .compact_en (compact_en),
    .unload_en  (unload_en),
    .sig_state  (sig_state)
);

// File: tb/sim_resp_compactor.sv
module sim_resp_compactor;
    localparam int NROWS = 4;
    localparam int NCLUS = 4;
    localparam int NCELL = 2;
    localparam logic [NROWS-1:0] TAPS = 4'hC;
    localparam int W = NROWS * NCLUS * NCELL;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] resp = '0;
    logic         ce = 1'b0;
    logic         ue = 1'b0;
    logic         sig;

    int checks = 0;
    int fails  = 0;
    logic [NROWS-1:0] model = '0;

    always #4 clk = ~clk;

    resp_compactor #(.NROWS(NROWS), .NCLUS(NCLUS), .NCELL(NCELL), .TAPS(TAPS)) u0 (
        .clk(clk), .rst(rst), .resp_i(resp), .compact_en(ce), .unload_en(ue), .sig_o(sig)
    );

    function automatic logic [NROWS-1:0] rows_of(input logic [W-1:0] v);
        logic [NROWS-1:0] r = '0;
        for (int ro = 0; ro < NROWS; ro++)
            for (int c = 0; c < NCLUS; c++)
                for (int k = 0; k < NCELL; k++)
                    r[ro] ^= v[(ro*NCLUS + c)*NCELL + k];
        return r;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Drive at negedge, let one posedge pass, update model, sample at next negedge.
    task automatic step(input logic [W-1:0] v, input logic c, input logic u, input string req);
        resp = v; ce = c; ue = u;
        @(posedge clk);
        if (u)      model = model >> 1;
        else if (c) model = (model >> 1) ^ (model[0] ? TAPS : '0) ^ rows_of(v);
        @(negedge clk);
        check(req, sig, model[0]);
    endtask

    task automatic unload_all(input string req);
        for (int i = 0; i < NROWS + 2; i++) step('0, 1'b0, 1'b1, req);
    endtask

    task automatic do_reset();
        rst = 1'b1; ce = 1'b0; ue = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = '0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();
        check("R4", sig, 1'b0);

        // R1 R2: single cells land on their row bit, observed by unloading
        for (int p = 0; p < W; p++) begin
            do_reset();
            step(W'(1) << p, 1'b1, 1'b0, "R1");
            unload_all("R2");
        end
        // R1: two cells of one cluster cancel
        do_reset();
        step(W'(3) << (2*NCELL), 1'b1, 1'b0, "R1");
        unload_all("R1");
        // R2: one cell in each of two clusters of row 1 cancel
        do_reset();
        step((W'(1) << (NCLUS*NCELL)) | (W'(1) << ((NCLUS+1)*NCELL)), 1'b1, 1'b0, "R2");
        unload_all("R2");

        // R5: hold with noisy response
        do_reset();
        step({W{1'b1}} ^ W'(1), 1'b1, 1'b0, "R3");
        for (int i = 0; i < 5; i++) step(W'($urandom), 1'b0, 1'b0, "R5");
        unload_all("R5");

        // R7: both enables set, response ignored
        do_reset();
        step(W'(32'h0000_00F1), 1'b1, 1'b0, "R3");
        step(W'($urandom), 1'b1, 1'b1, "R7");
        step(W'($urandom), 1'b1, 1'b1, "R7");
        unload_all("R7");

        // R3 R6: random folding with feedback, then unload
        for (int t = 0; t < 40; t++) begin
            do_reset();
            for (int n = 0; n < 20; n++) begin
                logic [2:0] m = 3'($urandom);
                step(W'($urandom), m != 3'd0, m == 3'd7, "R3");
            end
            unload_all("R6");
        end

        // R4: reset mid-run clears state
        step({W{1'b1}} ^ W'(1), 1'b1, 1'b0, "R3");
        do_reset();
        check("R4", sig, 1'b0);
        unload_all("R4");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1600000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule